// File: doc/BRIEF.md
# Transmit Channel Clock and Driver Guard

This block holds the control logic for one transmit channel of a line interface. Each cycle it decides which clock should time the channel's transmitter. The candidates are the shared master clock, the channel's own transmit clock input, and the clock recovered from the receive side. The choice depends on the channel's special modes, a chip-wide clock-select bit and the remote-loopback setting. The result leaves the block as a registered 2-bit code, which drives an external clock multiplexer.

The block also guards the line driver. A measured driver-current code arrives from the analog side and is compared against the active current limit. That limit is either a fixed default or a programmed 5-bit code, selected by an override bit. If the current rises above the limit, the block turns the driver off and latches a fault flag. The fault stays latched until software drops the output-enable bit and raises it again.

Top module: `tx_chan_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `clk_src` is 01, `drv_en` is 0 and `drv_fault` is 0.
- R2: A channel is in a special mode when any of `md_all_ones`, `md_auto_ones`, `md_sync2m` or `md_factory` is 1. If it is in a special mode and `glb_clk_sel` is 0, `clk_src` becomes 00 (master clock) at the next clock edge, whatever `rloop_en` is. `clk_src` changes only at a clock edge.
- R3: If the channel is in a special mode and `glb_clk_sel` is 1, `clk_src` becomes 01 (transmit clock input). With `rloop_en` at 1 it becomes 10 (recovered clock) instead.
- R4: Outside the special modes, `clk_src` is 01, or 10 when `rloop_en` is 1, whatever `glb_clk_sel` is. The code 11 never appears.
- R5: When `lim_ovr` is 0, the limit is the parameter `DEF_LIMIT`, which defaults to 31. With that default, no current code can set a fault.
- R6: When `lim_ovr` is 1, the limit is `lim_code`. A fault sets at the edge after `cur_code` is strictly greater than the limit while `out_en` is 1. A current equal to the limit sets no fault.
- R7: At the same edge where a fault sets, `drv_en` drops to 0. While `out_en` stays 1, `drv_fault` stays 1 and `drv_en` stays 0, even after the current falls.
- R8: An edge with `out_en` at 0 clears `drv_fault`. This holds even if over-current is present in that same cycle.
- R9: `drv_en` is 1 after an edge only if `out_en` was 1 and no fault was set or being set at that edge.
- R10: The two recommended programmed limits behave as follows. Limit 0x13 (75-ohm line) trips at 0x14 but not at 0x13. Limit 0x0F (120-ohm line) trips at 0x10 but not at 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| md_all_ones | input | 1 | Transmit-all-ones mode |
| md_auto_ones | input | 1 | Automatic all-ones mode |
| md_sync2m | input | 1 | 2048 kHz synchronization mode |
| md_factory | input | 1 | Factory test mode |
| rloop_en | input | 1 | Remote loopback active |
| glb_clk_sel | input | 1 | Chip-wide clock select: 0 = master clock in special modes, 1 = channel clock |
| lim_ovr | input | 1 | Use the programmed limit instead of the default |
| lim_code | input | 5 | Programmed current limit |
| out_en | input | 1 | Driver output-enable bit |
| cur_code | input | 5 | Measured driver-current code |
| clk_src | output | 2 | Clock source: 00 master, 01 transmit input, 10 recovered |
| drv_en | output | 1 | Line driver enable |
| drv_fault | output | 1 | Latched driver fault |

## Verification
Two of the block's functions can act on the same edge: over-current detection and the output-enable re-arm. The bench provokes this by applying an over-limit current in the very cycle `out_en` falls. The expected result is a clear fault flag and a disabled driver.

The bench also raises `out_en` in a cycle that already carries over-current. Here the fault must set and the driver must stay off, with no cycle of `drv_en` high in between.

Separately, the bench changes the clock mode while a fault is latched. This confirms that the clock-select path ignores the fault state.

// File: rtl/tx_chan_pkg.sv
package tx_chan_pkg;

    localparam int LIM_W = 5;

    typedef enum logic [1:0] {
        SRC_MASTER = 2'b00,
        SRC_TXIN   = 2'b01,
        SRC_RECOV  = 2'b10
    } clk_src_e;

    typedef struct packed {
        logic all_ones;
        logic auto_ones;
        logic sync2m;
        logic factory;
        logic rloop;
    } chan_mode_t;

    localparam logic [LIM_W-1:0] LIM_75OHM  = 5'h13;
    localparam logic [LIM_W-1:0] LIM_120OHM = 5'h0F;

    function automatic logic is_special(input chan_mode_t m);
        return m.all_ones | m.auto_ones | m.sync2m | m.factory;
    endfunction

    function automatic clk_src_e pick_src(input chan_mode_t m, input logic gsel);
        if (is_special(m) && !gsel) return SRC_MASTER;
        if (m.rloop)                return SRC_RECOV;
        return SRC_TXIN;
    endfunction

endpackage

// File: rtl/tx_clk_sel.sv
module tx_clk_sel
    import tx_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_t mode,
    input  logic       gsel,
    output clk_src_e   src
);

    clk_src_e src_q;

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_TXIN;
        else     src_q <= pick_src(mode, gsel);
    end

    assign src = src_q;

    p_master_in_special_r2: assert property (@(posedge clk) disable iff (rst)
        (is_special(mode) && !gsel) |=> (src == SRC_MASTER));

    p_never_master_plain_r4: assert property (@(posedge clk) disable iff (rst)
        (!is_special(mode) && !mode.rloop) |=> (src == SRC_TXIN));

    p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
        src != 2'b11);

endmodule

// File: rtl/tx_drv_guard.sv
module tx_drv_guard
    import tx_chan_pkg::*;
#(
    parameter int              W         = LIM_W,
    parameter logic [W-1:0]    DEF_LIMIT = '1
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         ovr,
    input  logic [W-1:0] lim,
    input  logic         oe,
    input  logic [W-1:0] cur,
    output logic         drv_en,
    output logic         fault
);

    logic [W-1:0] act_lim;
    logic         over;
    logic         fault_d;
    logic         fault_q;
    logic         en_q;

    assign act_lim = ovr ? lim : DEF_LIMIT;
    assign over    = cur > act_lim;

    always_comb begin
        if (!oe) fault_d = 1'b0;
        else     fault_d = fault_q | over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            fault_q <= fault_d;
            en_q    <= oe & ~fault_d;
        end
    end

    assign drv_en = en_q;
    assign fault  = fault_q;

    p_fault_kills_drv_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> !drv_en);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (fault && oe) |=> fault);

    p_oe_low_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !oe |=> !fault);

    p_drv_needs_oe_r9: assert property (@(posedge clk) disable iff (rst)
        !oe |=> !drv_en);

    p_trip_r6: assert property (@(posedge clk) disable iff (rst)
        (oe && ovr && (cur > lim)) |=> fault);

endmodule

// File: rtl/tx_chan_ctrl.sv
module tx_chan_ctrl
    import tx_chan_pkg::*;
#(
    parameter int           W         = LIM_W,
    parameter logic [W-1:0] DEF_LIMIT = 5'h1F
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         md_all_ones,
    input  logic         md_auto_ones,
    input  logic         md_sync2m,
    input  logic         md_factory,
    input  logic         rloop_en,
    input  logic         glb_clk_sel,
    input  logic         lim_ovr,
    input  logic [W-1:0] lim_code,
    input  logic         out_en,
    input  logic [W-1:0] cur_code,
    output logic [1:0]   clk_src,
    output logic         drv_en,
    output logic         drv_fault
);

    chan_mode_t mode;
    clk_src_e   src;

    assign mode = '{all_ones:  md_all_ones,
                    auto_ones: md_auto_ones,
                    sync2m:    md_sync2m,
                    factory:   md_factory,
                    rloop:     rloop_en};

    tx_clk_sel u_clk_sel (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .gsel (glb_clk_sel),
        .src  (src)
    );

    tx_drv_guard #(.W(W), .DEF_LIMIT(DEF_LIMIT)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .ovr    (lim_ovr),
        .lim    (lim_code),
        .oe     (out_en),
        .cur    (cur_code),
        .drv_en (drv_en),
        .fault  (drv_fault)
    );

    assign clk_src = src;

    p_default_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (!lim_ovr && cur_code <= DEF_LIMIT && !drv_fault) |=> !drv_fault);

endmodule

// File: tb/test_tx_chan_ctrl.sv
`timescale 1ns/1ps
module test_tx_chan_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       md_all_ones = 0, md_auto_ones = 0, md_sync2m = 0, md_factory = 0;
    logic       rloop_en = 0, glb_clk_sel = 0, lim_ovr = 0, out_en = 0;
    logic [4:0] lim_code = '0, cur_code = '0;
    logic [1:0] clk_src;
    logic       drv_en, drv_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tx_chan_ctrl i_tx_chan_ctrl (
        .clk(clk), .rst(rst),
        .md_all_ones(md_all_ones), .md_auto_ones(md_auto_ones),
        .md_sync2m(md_sync2m), .md_factory(md_factory),
        .rloop_en(rloop_en), .glb_clk_sel(glb_clk_sel),
        .lim_ovr(lim_ovr), .lim_code(lim_code), .out_en(out_en),
        .cur_code(cur_code), .clk_src(clk_src), .drv_en(drv_en),
        .drv_fault(drv_fault)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_modes(input logic [3:0] m);
        {md_all_ones, md_auto_ones, md_sync2m, md_factory} = m;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        out_en = 1'b1;
        step();
        chk("R1 clk_src", {6'b0, clk_src}, 8'h01);
        chk("R1 drv_en", {7'b0, drv_en}, 8'h00);
        chk("R1 drv_fault", {7'b0, drv_fault}, 8'h00);
        rst = 1'b0;
        out_en = 1'b0;
        step();
        chk("R1 after release", {6'b0, clk_src, drv_en, drv_fault}, 8'h04);
    endtask

    task automatic t_master();
        for (int i = 0; i < 4; i++) begin
            set_modes(4'b1000 >> i);
            glb_clk_sel = 1'b0;
            rloop_en = i[0];
            #1;
            chk("R2 no change before edge", {6'b0, clk_src}, 8'h01);
            step();
            chk("R2 master", {6'b0, clk_src}, 8'h00);
            set_modes(4'b0000);
            rloop_en = 1'b0;
            step();
        end
    endtask

    task automatic t_chan_sel();
        set_modes(4'b0010);
        glb_clk_sel = 1'b1;
        rloop_en = 1'b0;
        step();
        chk("R3 txin", {6'b0, clk_src}, 8'h01);
        rloop_en = 1'b1;
        step();
        chk("R3 recovered", {6'b0, clk_src}, 8'h02);
        set_modes(4'b0000);
        glb_clk_sel = 1'b0;
        rloop_en = 1'b0;
        step();
        chk("R4 plain gsel0", {6'b0, clk_src}, 8'h01);
        rloop_en = 1'b1;
        step();
        chk("R4 plain loop", {6'b0, clk_src}, 8'h02);
        glb_clk_sel = 1'b1;
        step();
        chk("R4 plain loop gsel1", {6'b0, clk_src}, 8'h02);
        rloop_en = 1'b0;
        step();
    endtask

    task automatic t_default_limit();
        lim_ovr = 1'b0;
        lim_code = 5'h00;
        out_en = 1'b1;
        cur_code = 5'h1F;
        step();
        step();
        chk("R5 no fault at max", {7'b0, drv_fault}, 8'h00);
        chk("R5 driver on", {7'b0, drv_en}, 8'h01);
    endtask

    task automatic t_trip(input logic [4:0] lim, input string tag);
        lim_ovr = 1'b1;
        lim_code = lim;
        out_en = 1'b0;
        cur_code = 5'h00;
        step();
        out_en = 1'b1;
        cur_code = lim;
        step();
        chk({tag, " equal no trip"}, {7'b0, drv_fault}, 8'h00);
        chk({tag, " driver on"}, {7'b0, drv_en}, 8'h01);
        cur_code = lim + 5'd1;
        step();
        chk({tag, " trip fault"}, {7'b0, drv_fault}, 8'h01);
        chk("R7 driver off at trip", {7'b0, drv_en}, 8'h00);
    endtask

    task automatic t_sticky_rearm();
        cur_code = 5'h00;
        step();
        step();
        chk("R7 fault held", {7'b0, drv_fault}, 8'h01);
        chk("R7 driver held off", {7'b0, drv_en}, 8'h00);
        set_modes(4'b0001);
        glb_clk_sel = 1'b0;
        step();
        chk("R2 clk_src with fault", {6'b0, clk_src}, 8'h00);
        set_modes(4'b0000);
        out_en = 1'b0;
        step();
        chk("R8 cleared", {7'b0, drv_fault}, 8'h00);
        chk("R9 off with oe low", {7'b0, drv_en}, 8'h00);
        out_en = 1'b1;
        step();
        chk("R8 re-armed driver", {7'b0, drv_en}, 8'h01);
    endtask

    task automatic t_same_cycle();
        lim_ovr = 1'b1;
        lim_code = 5'h0F;
        out_en = 1'b0;
        cur_code = 5'h1A;
        step();
        chk("R8 oe low beats overcurrent", {6'b0, drv_en, drv_fault}, 8'h00);
        out_en = 1'b1;
        step();
        chk("R9 raise oe into overcurrent", {6'b0, drv_en, drv_fault}, 8'h01);
        out_en = 1'b0;
        cur_code = 5'h00;
        step();
        out_en = 1'b1;
        step();
        chk("R9 clean enable", {6'b0, drv_en, drv_fault}, 8'h02);
    endtask

    initial begin
        #150000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_master();
        t_chan_sel();
        t_default_limit();
        t_trip(5'h13, "R10 75ohm R6");
        t_sticky_rearm();
        t_trip(5'h0F, "R10 120ohm R6");
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule